// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns internal access requests into bus cycles on an external bus that carries both address and data on one set of AD lines. A request gives an address, a byte or word size, write data and a direction. The controller drives the address latch strobe, the read strobe, the two write-side strobes and the shared AD lines. It samples a bus-width pin and a READY pin from the outside world.

A six-bit configuration word is captured when a request is accepted. It chooses whether the width is locked to 8 bits or follows the width pin on every bus cycle. It also picks the address strobe style and the write strobe style, and sets an upper limit on the wait states READY may insert. A word access that lands on an 8-bit cycle is split into two byte cycles. The read result is handed back once, with a one-cycle done pulse.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, and whenever idle, `req_ready` is high, all strobes are inactive (`rd_n`, `wr_n`, `bhe_n` high, `adr_stb` low) and `ad_oe` is low. A request is accepted when `req_valid` and `req_ready` are both high. Each access ends with `done` high for exactly one cycle, with `req_ready` already high and `rdata` valid for reads.
- R2: With `cfg[1]` = 0 every bus cycle is 8 bits wide, whatever `buswidth` is. Write data then sit on AD[7:0], and AD[15:8] carry zero during the data phase.
- R3: With `cfg[1]` = 1 the width of each bus cycle is taken from `buswidth` during its address phase: high gives 16 bits, low gives 8 bits.
- R4: Each bus cycle opens with one address phase lasting one clock. In that phase `ad_oe` is high, `ad_out` holds the address, `adr_stb` is high and `rd_n`/`wr_n` are high. The strobe phase follows, in which reads release the AD lines and writes drive data.
- R5: A word access ignores address bit 0. On an 8-bit cycle it runs as two bus cycles: the low byte at the even address first, then the high byte at the odd address. A read returns {high byte, low byte}.
- R6: `cfg[3]` = 0 gives a latch-enable strobe: `adr_stb` is high only during the address phase. `cfg[3]` = 1 gives an address-valid strobe: `adr_stb` stays high through the address and strobe phases.
- R7: With `cfg[2]` = 0, `wr_n` is low throughout the strobe phase of a write and never low together with `rd_n`. `bhe_n` is low during the address and strobe phases when the high byte lane is used, which happens on a 16-bit cycle for a word or for an odd address.
- R8: With `cfg[2]` = 1, `wr_n` is the low-byte write strobe and `bhe_n` is the high-byte write strobe, both active only in the strobe phase of writes. On a 16-bit cycle, an odd byte asserts only `bhe_n`, an even byte asserts only `wr_n`, and a word asserts both. On an 8-bit cycle only `wr_n` is asserted.
- R9: The strobe phase ends in the first clock in which `ready` is high. `cfg[5:4]` caps the wait states: 00 allows 1, 01 allows 2, 10 allows 3 and 11 sets no cap. The strobe phase therefore lasts at most cap+1 clocks.
- R10: A byte read on a 16-bit cycle takes AD[15:8] at an odd address and AD[7:0] at an even address. On an 8-bit cycle it always takes AD[7:0]. Byte reads return zero in `rdata[15:8]`.
- R11: The configuration is captured when a request is accepted. Changes to `cfg` during an access do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 6 | Configuration word: [1] dynamic width, [2] split write strobes, [3] address-valid style, [5:4] wait cap |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data (byte writes use [7:0]) |
| req_ready | output | 1 | Controller idle, request can be accepted |
| done | output | 1 | One-cycle access completion pulse |
| rdata | output | 16 | Read result |
| adr_stb | output | 1 | Address strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe or low-byte write strobe, active low |
| bhe_n | output | 1 | Byte-high enable or high-byte write strobe, active low |
| ad_oe | output | 1 | Drive enable for the AD lines |
| ad_out | output | AW | Address or write data driven onto AD |
| ad_in | input | AW | Values read back from AD |
| buswidth | input | 1 | External width pin, high = 16 bits |
| ready | input | 1 | External ready, high ends the strobe phase |

## Verification
The case that needs care is READY rising in exactly the clock where the internal wait limit expires. The strobe phase must then close once, with no extra clock. It must not end one clock early either, as an off-by-one in the cap compare would cause. The bench provokes this by releasing READY after as many waits as the cap allows, and also one wait earlier and well beyond it. It judges the result by counting strobe-phase clocks at the pins against min(READY delay, cap)+1.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    cfg,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [15:0]   rdata,
  output logic          adr_stb,
  output logic          rd_n,
  output logic          wr_n,
  output logic          bhe_n,
  output logic          ad_oe,
  output logic [AW-1:0] ad_out,
  input  logic [AW-1:0] ad_in,
  input  logic          buswidth,
  input  logic          ready
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_STRB} st_t;

  st_t          st;
  logic         q_we, q_word, part, w16;
  logic [5:0]   q_cfg;
  logic [AW-1:0] cur_a;
  logic [15:0]  q_wd;
  logic [1:0]   wcnt;

  logic in_a, in_s, bw_now, w16_eff, wcyc, hi_use, lo_use, cap_hit, end_s, split;
  logic [7:0]  wb, rb;
  logic [15:0] wlane, din;

  assign in_a    = (st == S_ADDR);
  assign in_s    = (st == S_STRB);
  assign bw_now  = q_cfg[1] & buswidth;
  assign w16_eff = in_a ? bw_now : w16;
  assign wcyc    = q_word & w16_eff & ~part;
  assign hi_use  = wcyc | (w16_eff & cur_a[0]);
  assign lo_use  = wcyc | ~(w16_eff & cur_a[0]);
  assign wb      = (q_word & part) ? q_wd[15:8] : q_wd[7:0];
  assign wlane   = wcyc ? q_wd : {(w16 ? wb : 8'h00), wb};
  assign cap_hit = (q_cfg[5:4] != 2'b11) && (wcnt == q_cfg[5:4] + 2'd1);
  assign end_s   = in_s & (ready | cap_hit);
  assign din     = ad_in[15:0];
  assign rb      = (w16 & cur_a[0]) ? din[15:8] : din[7:0];
  assign split   = q_word & ~w16 & ~part;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      q_we  <= 1'b0;
      q_word <= 1'b0;
      part  <= 1'b0;
      w16   <= 1'b0;
      q_cfg <= '0;
      cur_a <= '0;
      q_wd  <= '0;
      wcnt  <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          q_we   <= req_write;
          q_word <= req_word;
          q_wd   <= req_wdata;
          q_cfg  <= cfg;
          part   <= 1'b0;
          cur_a  <= req_word ? {req_addr[AW-1:1], 1'b0} : req_addr;
          st     <= S_ADDR;
        end
        S_ADDR: begin
          w16  <= bw_now;
          wcnt <= '0;
          st   <= S_STRB;
        end
        S_STRB: begin
          if (end_s) begin
            if (!q_we) begin
              if (wcyc)        rdata <= din;
              else if (q_word) begin
                if (part) rdata[15:8] <= rb;
                else      rdata[7:0]  <= rb;
              end else     rdata <= {8'h00, rb};
            end
            if (split) begin
              part  <= 1'b1;
              cur_a <= {cur_a[AW-1:1], 1'b1};
              st    <= S_ADDR;
            end else begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end else if (wcnt != 2'b11) begin
            wcnt <= wcnt + 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign ad_oe     = in_a | (in_s & q_we);
  assign ad_out    = in_a ? cur_a : ((in_s & q_we) ? AW'(wlane) : '0);
  assign rd_n      = ~(in_s & ~q_we);
  assign wr_n      = ~(in_s & q_we & (~q_cfg[2] | lo_use));
  assign bhe_n     = q_cfg[2] ? ~(in_s & q_we & hi_use) : ~((in_a | in_s) & hi_use);
  assign adr_stb   = in_a | (in_s & q_cfg[3]);
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       bhe_n,
  input logic       adr_stb,
  input logic       ad_oe,
  input logic       done,
  input logic       req_ready,
  input logic       in_s,
  input logic       qword,
  input logic [5:0] ccfg
);
  logic [2:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (in_s) run <= (run == 3'd7) ? run : run + 3'd1;
    else           run <= '0;
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  p_addr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> (rd_n && wr_n && adr_stb));
  p_le_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_stb && !ccfg[3]) |=> !adr_stb);
  p_no_rd_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_split_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_s && ccfg[2] && !qword) |-> (wr_n || bhe_n));
  p_wait_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_s && ccfg[5:4] != 2'b11) |-> (run <= 3'(ccfg[5:4]) + 3'd1));
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
  .adr_stb(adr_stb), .ad_oe(ad_oe), .done(done), .req_ready(req_ready),
  .in_s(in_s), .qword(q_word), .ccfg(q_cfg)
);

// File: tb/tb_xbus_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] cfg = '0;
  logic req_valid = 0, req_write = 0, req_word = 0;
  logic [15:0] req_addr = '0, req_wdata = '0, ad_in = '0;
  logic buswidth = 0, ready = 0;
  logic req_ready, done, adr_stb, rd_n, wr_n, bhe_n, ad_oe;
  logic [15:0] rdata, ad_out;

  always #2.5 clk = ~clk;

  xbus_ctrl #(.AW(16)) dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .adr_stb(adr_stb), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
    .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in), .buswidth(buswidth), .ready(ready));

  localparam logic [5:0] DYN = 6'h02, SPL = 6'h04, AV = 6'h08;

  int nchk = 0, nerr = 0;
  int gn; bit gdone, grdy;
  logic [15:0] grd;
  logic [15:0] ga [2];
  logic [15:0] gw [2];
  int glen [2];
  bit gwr [2], gbhe [2], gstb [2], gabhe [2];

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic int elen(input logic [5:0] c, input int ra);
    int cap = (c[5:4] == 2'b11) ? 1000 : int'(c[5:4]) + 1;
    return ((ra < cap) ? ra : cap) + 1;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic run(input bit we, input bit wd_word, input logic [15:0] a, input logic [15:0] wd,
                     input logic [5:0] c, input logic [5:0] c_after, input bit bw, input int ra);
    int sidx = 0;
    bit w16b = c[1] & bw;
    logic [15:0] cur = '0;
    gn = 0; gdone = 0; grdy = 0; grd = '0;
    for (int k = 0; k < 2; k++) begin
      ga[k] = '0; gw[k] = '0; glen[k] = 0; gwr[k] = 0; gbhe[k] = 0; gstb[k] = 0; gabhe[k] = 0;
    end
    @(negedge clk);
    cfg = c; buswidth = bw; req_write = we; req_word = wd_word; req_addr = a; req_wdata = wd;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0; cfg = c_after;
    for (int t = 0; t < 60 && !gdone; t++) begin
      bit strb = !rd_n || !wr_n || (c[2] && !bhe_n);
      if (done) begin
        gdone = 1; grd = rdata; grdy = req_ready;
      end else if (strb && gn > 0) begin
        if (sidx == 0) gw[gn-1] = ad_out;
        if (!wr_n) gwr[gn-1] = 1;
        if (!bhe_n) gbhe[gn-1] = 1;
        if (adr_stb) gstb[gn-1] = 1;
        glen[gn-1]++;
        ready = (sidx >= ra);
        ad_in = w16b ? {mem(cur | 16'h1), mem(cur & 16'hFFFE)} : {8'hEE, mem(cur)};
        sidx++;
      end else if (ad_oe && gn < 2) begin
        ga[gn] = ad_out; gabhe[gn] = !bhe_n; cur = ad_out;
        gn++; sidx = 0; ready = 0;
      end
      @(negedge clk);
    end
    ready = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset req_ready", req_ready, 1);
    chk("R1 reset strobes", {rd_n, wr_n, bhe_n, adr_stb, ad_oe, done}, 6'b111000);
  endtask

  task automatic t_word16_read;
    run(0, 1, 16'h1235, 0, DYN, DYN, 1, 0);
    chk("R3 one cycle", gn, 1);
    chk("R4 address", ga[0], 16'h1234);
    chk("R9 no-wait length", glen[0], 1);
    chk("R1 done seen", gdone, 1);
    chk("R1 ready at done", grdy, 1);
    chk("R1 word rdata", grd, 16'h6F6E);
    chk("R7 bhe in addr phase", gabhe[0], 1);
  endtask

  task automatic t_lock_read;
    run(0, 1, 16'h2040, 0, 6'h00, 6'h00, 1, 0);
    chk("R2 locked two cycles", gn, 2);
    chk("R5 first even", ga[0], 16'h2040);
    chk("R5 second odd", ga[1], 16'h2041);
    chk("R5 assembled", grd, 16'h1B1A);
  endtask

  task automatic t_split_write_std;
    run(1, 1, 16'h3000, 16'hBEEF, DYN, DYN, 0, 0);
    chk("R3 bw low two cycles", gn, 2);
    chk("R5 low byte first", gw[0], 16'h00EF);
    chk("R2 high byte second", gw[1], 16'h00BE);
    chk("R7 wr both", {gwr[0], gwr[1]}, 2'b11);
    chk("R7 no bhe on 8-bit", {gbhe[0], gbhe[1]}, 2'b00);
  endtask

  task automatic t_word16_write;
    run(1, 1, 16'h3002, 16'hCAFE, DYN, DYN, 1, 0);
    chk("R3 single", gn, 1);
    chk("R4 data", gw[0], 16'hCAFE);
    chk("R7 wr/bhe", {gwr[0], gbhe[0]}, 2'b11);
    chk("R6 latch style off in strobe", gstb[0], 0);
  endtask

  task automatic t_split_strobes;
    run(1, 0, 16'h4001, 16'h00A5, DYN | SPL, DYN | SPL, 1, 0);
    chk("R8 odd hi lane", gw[0][15:8], 8'hA5);
    chk("R8 odd hi only", {gwr[0], gbhe[0]}, 2'b01);
    run(1, 0, 16'h4000, 16'h00A5, DYN | SPL, DYN | SPL, 1, 0);
    chk("R8 even lo lane", gw[0][7:0], 8'hA5);
    chk("R8 even lo only", {gwr[0], gbhe[0]}, 2'b10);
    run(1, 1, 16'h4010, 16'h1234, SPL, SPL, 1, 0);
    chk("R8 8-bit word lo only", {gwr[0], gbhe[0], gwr[1], gbhe[1]}, 4'b1010);
    chk("R2 upper lane zero", gw[0][15:8], 8'h00);
    run(1, 1, 16'h4010, 16'h1234, DYN | SPL, DYN | SPL, 1, 0);
    chk("R8 16-bit word both", {gwr[0], gbhe[0]}, 2'b11);
  endtask

  task automatic t_byte_reads;
    run(0, 0, 16'h5003, 0, DYN | AV, DYN | AV, 1, 0);
    chk("R6 valid style in strobe", gstb[0], 1);
    chk("R10 odd from hi lane", grd, 16'h0059);
    run(0, 0, 16'h5002, 0, DYN, DYN, 1, 0);
    chk("R10 even from lo lane", grd, 16'h0058);
    run(0, 0, 16'h5003, 0, 6'h00, 6'h00, 1, 0);
    chk("R10 8-bit odd from lo lane", grd, 16'h0059);
  endtask

  task automatic t_waits;
    for (int cp = 0; cp < 3; cp++) begin
      logic [5:0] c = DYN | 6'(cp << 4);
      run(0, 0, 16'h0100, 0, c, c, 1, 10);
      chk("R9 cap reached", glen[0], elen(c, 10));
      run(0, 0, 16'h0100, 0, c, c, 1, cp + 1);
      chk("R9 ready on cap clock", glen[0], elen(c, cp + 1));
      run(0, 0, 16'h0100, 0, c, c, 1, cp);
      chk("R9 ready before cap", glen[0], elen(c, cp));
    end
    run(0, 0, 16'h0100, 0, DYN | 6'h30, DYN | 6'h30, 1, 5);
    chk("R9 unlimited", glen[0], 6);
  endtask

  task automatic t_cfg_capture;
    run(0, 1, 16'h6000, 0, 6'h00, DYN | AV, 1, 0);
    chk("R11 still split", gn, 2);
    chk("R11 still latch style", {gstb[0], gstb[1]}, 2'b00);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_word16_read();
    t_lock_read();
    t_split_write_std();
    t_word16_write();
    t_split_strobes();
    t_byte_reads();
    t_waits();
    t_cfg_capture();
    finish_run();
  end
endmodule